// File: doc/BRIEF.md
# Conversion Run Sequencer

This block decides when a converter runs and tells the rest of the chip when a fresh result can be read. A run is begun either by a start command strobe from the serial interface or by a start pin that has stayed high for a minimum number of consecutive clock cycles. Once running, an internal period timer produces one result every data period. The data period is `BASE_PERIOD` shifted left by a small rate-select field. The active-low data-ready flag drops each time a result lands and rises again when software begins to read it, or one cycle before the next result would overwrite it.

The block has two modes. In continuous mode, results repeat until a stop command arrives or the qualified start pin goes low. In single-shot mode, the block halts by itself after one result. Stopping is graceful: the conversion already in progress always completes. The latency from an accepted start to the first result is a fixed number of cycles for a given rate, so several blocks driven from one shared start pin stay aligned. A settled flag marks the fourth and later results after a start, because the first three results after a start are still affected by filter settling.

Top module: `conv_seq`

## Requirements
- R1: Right after reset, `drdy_o` is 1, `busy_o` is 0 and `settled_o` is 0.
- R2: `start_pin_i` starts a run only after it has been sampled high on `HOLD_CYCLES` consecutive clock edges (default 2). The run starts on the edge where the last of those samples is taken. A shorter high pulse has no effect.
- R3: A one-cycle `cmd_start_i` pulse starts a run. On the following cycle `busy_o` is 1 and `drdy_o` is 1. A start accepted while already running restarts the run from zero.
- R4: The first result, shown by `drdy_o` falling, arrives exactly P cycles after the edge that accepts the start, where P = `BASE_PERIOD` << `rate_sel_i`. The rate is sampled only at that accepting edge.
- R5: In continuous mode (`single_i` = 0), `drdy_o` falls again every P cycles for as long as the run continues.
- R6: While `drdy_o` is low, a `read_begin_i` pulse raises it on the next cycle. Without a read, it rises one cycle before the next result, so it is high for exactly one cycle before that result.
- R7: A `cmd_stop_i` pulse during a run lets the current conversion finish on schedule. At that result `busy_o` drops, and no further results follow.
- R8: A `cmd_stop_i` pulse while idle has no effect on `busy_o` or `drdy_o`.
- R9: When a qualified start pin goes low, the block stops in the same graceful way as R7.
- R10: In single-shot mode (`single_i` = 1), the run ends with its first result. `busy_o` is 0 from that result on.
- R11: `settled_o` rises together with the fourth result after a start and stays high until the next start. Every accepted start clears it and restarts the count from zero.
- R12: A start accepted during a run restarts the period timer, so the next result comes P cycles after the restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_pin_i | input | 1 | Level start pin, qualified by hold time |
| cmd_start_i | input | 1 | One-cycle start command strobe |
| cmd_stop_i | input | 1 | One-cycle stop command strobe |
| single_i | input | 1 | 1 = single-shot mode, 0 = continuous |
| rate_sel_i | input | RATE_W | Data period select: P = BASE_PERIOD << rate_sel_i |
| read_begin_i | input | 1 | Pulse when a read of the current result begins |
| drdy_o | output | 1 | Data ready, active low |
| busy_o | output | 1 | 1 while a conversion run is active |
| settled_o | output | 1 | Current result is past the settling window |

## Verification
The bound checker watches every cycle for four things:
- Every accepted start arms `busy_o` and `drdy_o`.
- `drdy_o` only falls while a run is active.
- A single-shot result always ends the run.
- A stop command while idle leaves the block idle.

It also checks that `settled_o` only rises together with a result. The exact spacing of results, the graceful drain after a command or pin stop, the early rise of `drdy_o` before a result, and the latching of the rate at the start edge all need whole scenarios. The bench covers those by comparing against its reference model on every clock.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } seq_state_t;
endpackage

// File: rtl/conv_start_qual.sv
// Qualifies a level start pin: a start fires once after HOLD_CYCLES highs,
// and a stop fires when a qualified pin returns low.
module conv_start_qual #(
  parameter int HOLD_CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic pin_i,
  output logic go_o,
  output logic stop_o
);
  localparam int HW = $clog2(HOLD_CYCLES + 1);

  logic [HW-1:0] high_cnt_q;

  assign go_o   = pin_i && (high_cnt_q == HW'(HOLD_CYCLES - 1));
  assign stop_o = !pin_i && (high_cnt_q == HW'(HOLD_CYCLES));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      high_cnt_q <= '0;
    end else if (!pin_i) begin
      high_cnt_q <= '0;
    end else if (high_cnt_q != HW'(HOLD_CYCLES)) begin
      high_cnt_q <= high_cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/conv_period_timer.sv
// Counts one data period; flags its last cycle and the cycle before it.
module conv_period_timer #(
  parameter int PER_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             restart_i,
  input  logic             enable_i,
  input  logic [PER_W-1:0] period_i,
  output logic             done_o,
  output logic             near_o
);
  logic [PER_W-1:0] cnt_q;

  assign done_o = enable_i && (cnt_q == period_i - PER_W'(1));
  assign near_o = enable_i && (cnt_q == period_i - PER_W'(2));

  always_ff @(posedge clk_i) begin
    if (rst_i || restart_i) begin
      cnt_q <= '0;
    end else if (enable_i) begin
      cnt_q <= done_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/conv_seq.sv
module conv_seq
  import conv_seq_pkg::*;
#(
  parameter int BASE_PERIOD    = 4,
  parameter int RATE_W         = 3,
  parameter int HOLD_CYCLES    = 2,
  parameter int SETTLE_RESULTS = 4
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              start_pin_i,
  input  logic              cmd_start_i,
  input  logic              cmd_stop_i,
  input  logic              single_i,
  input  logic [RATE_W-1:0] rate_sel_i,
  input  logic              read_begin_i,
  output logic              drdy_o,
  output logic              busy_o,
  output logic              settled_o
);
  localparam int MAX_PERIOD = BASE_PERIOD << ((1 << RATE_W) - 1);
  localparam int PER_W      = $clog2(MAX_PERIOD + 1);
  localparam int CNT_W      = $clog2(SETTLE_RESULTS + 1);

  seq_state_t       state_q;
  logic [PER_W-1:0] period_q;
  logic [CNT_W-1:0] res_cnt_q;
  logic             drdy_q;
  logic             settled_q;

  logic pin_go, pin_stop, start_go, stop_req, tick, near;

  conv_start_qual #(.HOLD_CYCLES(HOLD_CYCLES)) u_qual (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .pin_i  (start_pin_i),
    .go_o   (pin_go),
    .stop_o (pin_stop)
  );

  conv_period_timer #(.PER_W(PER_W)) u_timer (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .restart_i (start_go),
    .enable_i  (state_q != ST_IDLE),
    .period_i  (period_q),
    .done_o    (tick),
    .near_o    (near)
  );

  assign start_go = cmd_start_i || pin_go;
  assign stop_req = cmd_stop_i || pin_stop;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q   <= ST_IDLE;
      period_q  <= PER_W'(BASE_PERIOD);
      res_cnt_q <= '0;
      drdy_q    <= 1'b1;
      settled_q <= 1'b0;
    end else if (start_go) begin
      state_q   <= ST_RUN;
      period_q  <= PER_W'(BASE_PERIOD) << rate_sel_i;
      res_cnt_q <= '0;
      drdy_q    <= 1'b1;
      settled_q <= 1'b0;
    end else begin
      case (state_q)
        ST_RUN, ST_DRAIN: begin
          if (tick) begin
            drdy_q <= 1'b0;
            if (res_cnt_q != CNT_W'(SETTLE_RESULTS))
              res_cnt_q <= res_cnt_q + 1'b1;
            if (res_cnt_q >= CNT_W'(SETTLE_RESULTS - 1))
              settled_q <= 1'b1;
            if (single_i || stop_req || state_q == ST_DRAIN)
              state_q <= ST_IDLE;
          end else begin
            if (stop_req)
              state_q <= ST_DRAIN;
            if (near || read_begin_i)
              drdy_q <= 1'b1;
          end
        end
        default: begin
          if (read_begin_i)
            drdy_q <= 1'b1;
        end
      endcase
    end
  end

  assign drdy_o    = drdy_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign settled_o = settled_q;
endmodule

// File: rtl/conv_seq_checker.sv
module conv_seq_checker (
  input logic clk_i,
  input logic rst_i,
  input logic go_i,
  input logic cmd_stop_i,
  input logic single_i,
  input logic busy_o,
  input logic drdy_o,
  input logic settled_o
);
  // R3: an accepted start arms the run and raises data-ready
  a_r3_start_arms: assert property (@(posedge clk_i) disable iff (rst_i)
    go_i |=> (busy_o && drdy_o));

  // R5: results only land during a run
  a_r5_fall_in_run: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(drdy_o) |-> $past(busy_o));

  // R10: a single-shot result ends the run
  a_r10_single_halts: assert property (@(posedge clk_i) disable iff (rst_i)
    ($fell(drdy_o) && $past(single_i)) |-> !busy_o);

  // R8: stop while idle keeps the block idle
  a_r8_stop_idle: assert property (@(posedge clk_i) disable iff (rst_i)
    (!busy_o && cmd_stop_i && !go_i) |=> !busy_o);

  // R11: settled rises only together with a result
  a_r11_settle_on_result: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(settled_o) |-> $fell(drdy_o));
endmodule

bind conv_seq conv_seq_checker u_chk (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .go_i       (start_go),
  .cmd_stop_i (cmd_stop_i),
  .single_i   (single_i),
  .busy_o     (busy_o),
  .drdy_o     (drdy_o),
  .settled_o  (settled_o)
);

// File: tb/tb_conv_seq.sv
module tb_conv_seq;
  localparam int CLK_PERIOD = 10;
  localparam int BASE       = 4;

  logic clk = 0, rst = 1;
  logic start_pin = 0, cmd_start = 0, cmd_stop = 0, single = 0, read_begin = 0;
  logic [2:0] rate = 0;
  logic drdy, busy, settled;

  int n_checks = 0, n_fail = 0, cyc = 0;
  string cur_tag = "R1";

  conv_seq dut (
    .clk_i(clk), .rst_i(rst), .start_pin_i(start_pin), .cmd_start_i(cmd_start),
    .cmd_stop_i(cmd_stop), .single_i(single), .rate_sel_i(rate),
    .read_begin_i(read_begin), .drdy_o(drdy), .busy_o(busy), .settled_o(settled)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  bit m_busy, m_stop, m_drdy, m_set, m_prev, m_fired;
  int m_t, m_per, m_cnt;
  always @(posedge clk) begin
    bit pgo, pstop, go, stp;
    cyc++;
    if (rst) begin
      m_busy = 0; m_stop = 0; m_drdy = 1; m_set = 0; m_prev = 0; m_fired = 0;
      m_t = 0; m_per = BASE; m_cnt = 0;
    end else begin
      pgo   = start_pin && m_prev && !m_fired;
      pstop = !start_pin && m_fired;
      m_fired = start_pin ? (m_fired || pgo) : 1'b0;
      m_prev  = start_pin;
      go  = cmd_start || pgo;
      stp = cmd_stop || pstop;
      if (go) begin
        m_busy = 1; m_stop = 0; m_t = 0; m_per = BASE << rate;
        m_drdy = 1; m_cnt = 0; m_set = 0;
      end else if (m_busy) begin
        if (m_t == m_per - 1) begin
          m_drdy = 0; m_cnt++; if (m_cnt >= 4) m_set = 1; m_t = 0;
          if (single || m_stop || stp) m_busy = 0;
        end else begin
          if (stp) m_stop = 1;
          if (m_t == m_per - 2 || read_begin) m_drdy = 1;
          m_t++;
        end
      end else if (read_begin) m_drdy = 1;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk({cur_tag, " model drdy"}, drdy, m_drdy);
      chk({cur_tag, " model busy"}, busy, m_busy);
      chk({cur_tag, " model settled"}, settled, m_set);
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic pulse_start; cmd_start = 1; @(negedge clk); cmd_start = 0; endtask
  task automatic pulse_stop;  cmd_stop  = 1; @(negedge clk); cmd_stop  = 0; endtask
  task automatic pulse_read;  read_begin = 1; @(negedge clk); read_begin = 0; endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    wait_n(3); rst = 0; wait_n(1);
    cur_tag = "R1";
    chk("R1 drdy", drdy, 1); chk("R1 busy", busy, 0); chk("R1 settled", settled, 0);

    cur_tag = "R2";
    start_pin = 1; wait_n(1); start_pin = 0; wait_n(3);
    chk("R2 short pulse ignored", busy, 0);
    start_pin = 1; wait_n(1); chk("R2 one high sample", busy, 0);
    wait_n(1); chk("R2 two high samples", busy, 1);

    cur_tag = "R4";
    wait_n(3); chk("R4 before first result", drdy, 1);
    wait_n(1); chk("R4 first result P=4", drdy, 0);

    cur_tag = "R9";
    start_pin = 0;
    wait_n(3); chk("R9 drain busy", busy, 1);
    wait_n(1); chk("R9 drained busy", busy, 0); chk("R9 last result", drdy, 0);
    wait_n(10); chk("R9 stays idle", busy, 0);

    cur_tag = "R6";
    pulse_read; chk("R6 read in idle", drdy, 1);

    cur_tag = "R3";
    rate = 1; pulse_start;
    chk("R3 busy", busy, 1); chk("R3 drdy", drdy, 1);
    cur_tag = "R5";
    wait_n(7); chk("R5 before result", drdy, 1);
    wait_n(1); chk("R5 first P=8", drdy, 0);
    cur_tag = "R6";
    pulse_read; chk("R6 read raises drdy", drdy, 1);
    cur_tag = "R5";
    wait_n(7); chk("R5 second result", drdy, 0);
    cur_tag = "R6";
    wait_n(6); chk("R6 low until prefetch", drdy, 0);
    wait_n(1); chk("R6 prefetch high", drdy, 1);
    wait_n(1); chk("R6 third result", drdy, 0);
    cur_tag = "R11";
    wait_n(7); chk("R11 not settled at 3", settled, 0);
    wait_n(1); chk("R11 settled at 4th", settled, 1);

    cur_tag = "R12";
    pulse_start; chk("R12 restart clears settled", settled, 0);
    wait_n(7); chk("R12 no early result", drdy, 1);
    wait_n(1); chk("R12 result P after restart", drdy, 0);

    cur_tag = "R7";
    pulse_stop;
    wait_n(6); chk("R7 still busy", busy, 1);
    wait_n(1); chk("R7 ends at result", busy, 0); chk("R7 result landed", drdy, 0);
    wait_n(20); chk("R7 no more results", drdy, 0); chk("R7 idle", busy, 0);

    cur_tag = "R8";
    pulse_stop; chk("R8 busy", busy, 0); chk("R8 drdy", drdy, 0);

    cur_tag = "R4";
    rate = 2; pulse_start; rate = 0;
    wait_n(15); chk("R4 rate latched, early", drdy, 1);
    wait_n(1); chk("R4 rate latched P=16", drdy, 0);
    pulse_stop; wait_n(40); chk("R7 stopped", busy, 0);

    cur_tag = "R10";
    single = 1; pulse_start;
    wait_n(3); chk("R10 running", busy, 1);
    wait_n(1); chk("R10 result", drdy, 0); chk("R10 halted", busy, 0);
    wait_n(10); chk("R10 no repeat", drdy, 0);

    cur_tag = "R11";
    for (int i = 0; i < 4; i++) begin
      pulse_start; wait_n(6);
    end
    chk("R11 single restarts count", settled, 0);
    wait_n(5);
    finish_run;
  end

  initial begin
    wait (cyc > 20000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run;
  end
endmodule